// File: doc/BRIEF.md
# Sticky-Pending Interrupt Controller

This block sits between a set of external interrupt request lines and a processor core. Each request line is sampled on the rising clock edge and recorded in a per-line pending flag. The flag stays set after the line drops. Software enables or masks each line through an enable register. Of the lines that are both pending and enabled, the one with the lowest index is offered to the core as a request plus a vector number. The core uses the vector as an offset into its handler table.

When the core enters the handler, it pulses an acknowledge. The pending flag of the source being offered is then cleared at that edge. Software can also raise or withdraw pending flags through a small single-cycle register port. A flag withdrawn before acknowledge is never delivered.

The port has four word offsets, selected by `reg_addr`:
- Offset 0: write 1 to set pending flags; reads the pending flags.
- Offset 1: write 1 to clear pending flags; reads the pending flags.
- Offset 2: the enable register, read and written as a whole.
- Offset 3: reserved.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After a synchronous reset, every pending flag and every enable bit is 0 and `irq_req` is 0.
- R2: A line sampled high on a rising edge sets its pending flag at that edge. The flag stays 1 after the line returns low, until it is acknowledged or cleared by software.
- R3: When `irq_ack` is 1 while `irq_req` is 1, the flag of the source shown on `irq_vec` is cleared at that edge. All other flags are unchanged.
- R4: If the line of the acknowledged source is high in the acknowledge cycle, its flag remains 1.
- R5: Writing to offset 1 clears each pending flag whose `reg_wdata` bit is 1, and it wins over a request in the same cycle. Bits written as 0 change nothing. A source cleared this way before acknowledge is never presented on `irq_vec`.
- R6: Writing to offset 0 sets each pending flag whose `reg_wdata` bit is 1. Bits written as 0 change nothing.
- R7: A pending source whose enable bit is 0 keeps its flag but is not presented. `irq_req` is 1 exactly when some source is both pending and enabled.
- R8: `irq_vec` carries the lowest index among sources that are both pending and enabled.
- R9: `irq_req` and `irq_vec` follow the registered flags with no added delay: they reflect a state change in the cycle that follows the edge that made it.
- R10: A line still high after a software clear sets its flag again at the next edge, so the flag reads 0 for exactly one cycle.
- R11: Offset 2 writes the enable register in full and reads it back. Offsets 0 and 1 read the pending flags. Offset 3 reads 0, and writes to it change nothing.
- R12: `irq_ack` while `irq_req` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Level-sensitive request lines |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_vec | output | VEC_W | Index of the offered source |
| irq_ack | input | 1 | Core has entered the handler of the offered source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data, combinational from `reg_addr` |

## Verification
A pending flag that is lost, stuck, or cleared on the wrong source shows up at the ports in the first low clock phase after the faulty edge. It appears as a wrong `irq_req` or `irq_vec`, or as a wrong value read at offset 0. A corrupted enable bit shows up the same way, through offset 2 and through the gating of `irq_req`.

Every output is compared each cycle against a reference model kept in the bench. A fault is therefore caught within one cycle of the edge that caused it, not when a handler later misbehaves. Directed sequences cover these collisions:
- request against acknowledge;
- request against software clear;
- acknowledge with nothing offered;
- the reserved offset.

// File: rtl/irq_latch_pkg.sv
`timescale 1ns/1ps
package irq_latch_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        OFS_PEND_SET = 2'd0,
        OFS_PEND_CLR = 2'd1,
        OFS_ENABLE   = 2'd2,
        OFS_RESERVED = 2'd3
    } reg_ofs_e;

    // decoded write strobes from the register port
    typedef struct packed {
        logic set_pend;
        logic clr_pend;
        logic wr_en;
    } wr_strobe_t;

    function automatic int vec_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] line_in,
    input  logic [N_SRC-1:0] sw_set,
    input  logic [N_SRC-1:0] sw_clr,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] pend_q
);
    // per source: ack clear loses to a live request, software clear wins over all
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        logic held;
        logic nxt;
        always_comb begin
            held = pend_q[i] & ~ack_clr[i];
            nxt  = (held | line_in[i] | sw_set[i]) & ~sw_clr[i];
        end
        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= nxt;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel #(
    parameter int N_SRC = 8,
    parameter int VEC_W = 3
) (
    input  logic [N_SRC-1:0] cand,
    output logic [N_SRC-1:0] grant,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    // lower_seen[i] is 1 when some candidate below index i exists
    logic [N_SRC:0] lower_seen;
    assign lower_seen[0] = 1'b0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_chain
        assign grant[i]        = cand[i] & ~lower_seen[i];
        assign lower_seen[i+1] = lower_seen[i] | cand[i];
    end

    assign any = lower_seen[N_SRC];

    always_comb begin
        vec = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) vec = vec | VEC_W'(i);
        end
    end
endmodule

// File: rtl/irq_regport.sv
`timescale 1ns/1ps
module irq_regport
    import irq_latch_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [N_SRC-1:0]      reg_wdata,
    input  logic [N_SRC-1:0]      pend_q,
    output logic [N_SRC-1:0]      en_q,
    output logic [N_SRC-1:0]      sw_set,
    output logic [N_SRC-1:0]      sw_clr,
    output logic [N_SRC-1:0]      reg_rdata
);
    wr_strobe_t stb;
    reg_ofs_e   ofs;

    always_comb begin
        ofs          = reg_ofs_e'(reg_addr);
        stb          = '0;
        stb.set_pend = reg_we && (ofs == OFS_PEND_SET);
        stb.clr_pend = reg_we && (ofs == OFS_PEND_CLR);
        stb.wr_en    = reg_we && (ofs == OFS_ENABLE);
    end

    assign sw_set = stb.set_pend ? reg_wdata : '0;
    assign sw_clr = stb.clr_pend ? reg_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst)            en_q <= '0;
        else if (stb.wr_en) en_q <= reg_wdata;
    end

    always_comb begin
        unique case (ofs)
            OFS_PEND_SET, OFS_PEND_CLR: reg_rdata = pend_q;
            OFS_ENABLE:                 reg_rdata = en_q;
            default:                    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_latch_ctrl.sv
`timescale 1ns/1ps
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int VEC_W = vec_width(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SRC-1:0]      irq_in,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vec,
    input  logic                  irq_ack,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [N_SRC-1:0]      reg_wdata,
    output logic [N_SRC-1:0]      reg_rdata
);
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] sw_set;
    logic [N_SRC-1:0] sw_clr;
    logic [N_SRC-1:0] grant;
    logic [N_SRC-1:0] ack_clr;
    logic [N_SRC-1:0] cand;

    assign cand    = pend_q & en_q;
    // only the source being offered is retired by an acknowledge
    assign ack_clr = (irq_ack && irq_req) ? grant : '0;

    irq_regport #(.N_SRC(N_SRC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q),
        .en_q      (en_q),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .reg_rdata (reg_rdata)
    );

    irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .line_in (irq_in),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .ack_clr (ack_clr),
        .pend_q  (pend_q)
    );

    irq_prio_sel #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_sel (
        .cand  (cand),
        .grant (grant),
        .any   (irq_req),
        .vec   (irq_vec)
    );
endmodule

// File: rtl/irq_latch_chk.sv
`timescale 1ns/1ps
module irq_latch_chk
    import irq_latch_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int VEC_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N_SRC-1:0]      irq_in,
    input logic                  irq_req,
    input logic [VEC_W-1:0]      irq_vec,
    input logic                  irq_ack,
    input logic                  reg_we,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [N_SRC-1:0]      reg_wdata,
    input logic [N_SRC-1:0]      pend_q,
    input logic [N_SRC-1:0]      en_q
);
    logic clr_wr;
    logic set_wr;
    assign clr_wr = reg_we && (reg_addr == OFS_PEND_CLR);
    assign set_wr = reg_we && (reg_addr == OFS_PEND_SET);

    // R2: a sampled line is latched unless software clears in that cycle
    p_line_latched_r2: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((pend_q & $past(irq_in)) == $past(irq_in)));

    // R2: with no acknowledge and no clear, no flag drops
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (!(irq_ack && irq_req) && !clr_wr) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R3: the acknowledged source is retired when its line is low
    p_ack_retires_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && !irq_in[irq_vec] && !set_wr) |=> !pend_q[$past(irq_vec)]);

    // R5: software clear empties the written flags at the next edge
    p_swclr_r5: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((pend_q & $past(reg_wdata)) == '0));

    // R6: software set fills the written flags at the next edge
    p_swset_r6: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((pend_q & $past(reg_wdata)) == $past(reg_wdata)));

    // R7: no request while nothing enabled is pending
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & en_q) == '0) |-> !irq_req);

    // R8: offered source is pending and enabled, with no enabled pending one below it
    p_vec_valid_r8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (pend_q[irq_vec] && en_q[irq_vec]));
    p_vec_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((pend_q & en_q & ((N_SRC'(1) << irq_vec) - N_SRC'(1))) == '0));

    // R12: acknowledge with nothing offered changes no flag apart from new lines and sets
    p_idle_ack_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_req && !clr_wr) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind irq_latch_ctrl irq_latch_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend_q    (pend_q),
    .en_q      (en_q)
);

// File: tb/sim_irq_latch_ctrl.sv
`timescale 1ns/1ps
module sim_irq_latch_ctrl;
    localparam int N  = 8;
    localparam int VW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          irq_req;
    logic [VW-1:0] irq_vec;
    logic          irq_ack = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_en = '0;
    logic [N-1:0] t_nxt;

    always #10 clk = ~clk;

    irq_latch_ctrl #(.N_SRC(N)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int f_lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] f_read(input logic [1:0] a);
        if (a == 2'd0 || a == 2'd1) return m_pend;
        if (a == 2'd2) return m_en;
        return '0;
    endfunction

    // reference model, built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_pend <= '0;
            m_en   <= '0;
        end else begin
            t_nxt = m_pend;
            if (irq_ack && f_lowest(m_pend & m_en) >= 0) t_nxt[f_lowest(m_pend & m_en)] = 1'b0;
            t_nxt = t_nxt | irq_in;
            if (reg_we && reg_addr == 2'd0) t_nxt = t_nxt | reg_wdata;
            if (reg_we && reg_addr == 2'd1) t_nxt = t_nxt & ~reg_wdata;
            if (reg_we && reg_addr == 2'd2) m_en <= reg_wdata;
            m_pend <= t_nxt;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compares request, vector and all readable offsets; runs in the low phase
    task automatic compare_all();
        int w;
        w = f_lowest(m_pend & m_en);
        chk("irq_req", int'(irq_req), (w >= 0) ? 1 : 0);
        if (w >= 0) chk("irq_vec", int'(irq_vec), w);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            chk($sformatf("rdata@%0d", a), int'(reg_rdata), int'(f_read(2'(a))));
        end
    endtask

    task automatic step(input logic [N-1:0] lines, input logic ack, input logic we,
                        input logic [1:0] a, input logic [N-1:0] d);
        irq_in = lines; irq_ack = ack; reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0; reg_we = 1'b0;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1"; compare_all();
        chk("R1 reset req", int'(irq_req), 0);

        tag = "R11"; step('0, 0, 1, 2'd2, 8'hA5);
        chk("R11 enable readback", int'(u0.reg_rdata === reg_rdata), 1);
        step('0, 0, 1, 2'd3, 8'hFF);
        step('0, 0, 0, 2'd0, '0);

        tag = "R2"; step(8'h10, 0, 0, 2'd0, '0);
        step('0, 0, 0, 2'd0, '0);
        reg_addr = 2'd0; #1; chk("R2 sticky bit4", int'(reg_rdata[4]), 1);
        tag = "R7"; chk("R7 masked no req", int'(irq_req), 0);

        tag = "R9"; step('0, 0, 1, 2'd2, 8'hFF);
        chk("R9 req next cycle", int'(irq_req), 1);
        tag = "R8"; chk("R8 vec", int'(irq_vec), 4);
        step(8'h41, 0, 0, 2'd0, '0);
        chk("R8 lowest", int'(irq_vec), 0);

        tag = "R3"; step('0, 1, 0, 2'd0, '0);
        chk("R3 next vec", int'(irq_vec), 4);
        tag = "R4"; step(8'h10, 1, 0, 2'd0, '0);
        chk("R4 kept", int'(irq_vec), 4);

        tag = "R12"; step('0, 0, 1, 2'd2, 8'h00);
        step('0, 1, 0, 2'd0, '0);
        reg_addr = 2'd0; #1; chk("R12 flags kept", int'(reg_rdata), 8'h50);

        tag = "R6"; step('0, 0, 1, 2'd0, 8'h02);
        reg_addr = 2'd1; #1; chk("R6 set", int'(reg_rdata), 8'h52);
        tag = "R5"; step('0, 0, 1, 2'd1, 8'h52);
        step('0, 0, 1, 2'd2, 8'hFF);
        chk("R5 never offered", int'(irq_req), 0);

        tag = "R10"; step(8'h08, 0, 0, 2'd0, '0);
        step(8'h08, 0, 1, 2'd1, 8'h08);
        reg_addr = 2'd0; #1; chk("R10 cleared", int'(reg_rdata[3]), 0);
        step(8'h08, 0, 0, 2'd0, '0);
        reg_addr = 2'd0; #1; chk("R10 repended", int'(reg_rdata[3]), 1);

        tag = "R8 random";
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] ln;
            ln = ($urandom_range(0, 3) == 0) ? N'($urandom & $urandom) : '0;
            step(ln, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 4) == 0),
                 2'($urandom), N'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule